// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Free-Running Timebase

This block is a watchdog that software programs over a simple 32-bit register bus. While it is enabled, an interval counter wraps every 2^N clock cycles. The first wrap is a warning: it sets a state flag and raises an interrupt. If software has not cleared that flag by the next wrap, the block latches a reset-status flag and drives a system reset pulse of fixed length. Software keeps the system alive by writing a one to the state flag, which clears the flag and restarts the interval.

Two enable bits, one in each control register, start the counter. The counter stops only when both bits are clear. A build-time option locks the watchdog on once it has started, so that software can no longer stop it. A third register gives a free-running timebase counter, which software can read twice to confirm that the clock is alive.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, all three registers read zero, and `irq` and `sys_rst` are low.
- R2: Byte offset 0x0 is control/status 0: bit 1 is enable A (read/write), bit 2 is the state flag, bit 3 is the reset-status flag, and all other bits read zero. Byte offset 0x4 is control/status 1: bit 0 is enable B (read/write), and all other bits read zero.
- R3: The interval counter advances while enable A or enable B is set. With both enables clear, the counter is held at zero and no expiry occurs.
- R4: The first expiry, 2^N cycles after the enabling write or after the last restart, sets the state flag. `irq` is a level equal to the state flag.
- R5: An expiry while the state flag is already set does three things: it sets the reset-status flag, it drives `sys_rst` high for exactly RST_PULSE cycles, and it leaves the reset-status flag set after the pulse ends.
- R6: Writing 1 to bit 2 at offset 0x0 clears the state flag and restarts the interval from zero. Writing 1 to bit 3 clears the reset-status flag. Writing 0 to either bit leaves that flag unchanged.
- R7: Byte offset 0x8 reads a free-running counter that increases by exactly one every clock cycle.
- R8: With ENABLE_ONCE set, once either enable is set, writes that would clear an enable bit are ignored. The counter keeps running.
- R9: Reads of any other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_addr | input | 4 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Warning interrupt, level |
| sys_rst | output | 1 | System reset pulse |

## Verification
The bench sweeps the full two-interval timeline, cycle by cycle, on a small interval. A design that counted one cycle off, or reset on the first wrap, would set the state flag or fire `sys_rst` in the wrong cycle, and a wrong pulse length shows up in the pulse's last cycle. It checks four further cases: a keepalive that does not restart the interval, a zero written to a flag bit that still clears it, a counter that stops when only one enable is cleared, and an enable-once lock that fails to hold enable B. Each of these would move or suppress the next expiry, or change an enable bit on readback. Unmapped offsets are probed to catch address decoding that aliases onto the control registers.

// File: rtl/twostage_wdog.sv
module twostage_wdog #(
  parameter int INTERVAL_LOG2 = 8,
  parameter int RST_PULSE     = 4,
  parameter bit ENABLE_ONCE   = 1'b0,
  parameter int TB_W          = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sys_rst
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic                     en_a, en_b, state_q, rstflag_q;
  logic [INTERVAL_LOG2-1:0] ivl_q;
  logic [PW-1:0]            pulse_q;
  logic [TB_W-1:0]          tb_q;

  wire run    = en_a | en_b;
  wire lock   = ENABLE_ONCE & run;
  wire wr_c0  = bus_we && (bus_addr == 4'h0);
  wire wr_c1  = bus_we && (bus_addr == 4'h4);
  wire kick   = wr_c0 && bus_wdata[2];
  wire expire = run && !kick && (ivl_q == '1);
  wire bite   = expire && state_q;
  wire unused_wdata = ^bus_wdata[31:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a      <= 1'b0;
      en_b      <= 1'b0;
      state_q   <= 1'b0;
      rstflag_q <= 1'b0;
      ivl_q     <= '0;
      pulse_q   <= '0;
      tb_q      <= '0;
    end else begin
      tb_q <= tb_q + 1'b1;
      if (wr_c0) en_a <= bus_wdata[1] | (lock & en_a);
      if (wr_c1) en_b <= bus_wdata[0] | (lock & en_b);
      if (!run || kick) ivl_q <= '0;
      else              ivl_q <= ivl_q + 1'b1;
      if (kick)        state_q <= 1'b0;
      else if (expire) state_q <= 1'b1;
      if (bite)                         rstflag_q <= 1'b1;
      else if (wr_c0 && bus_wdata[3])   rstflag_q <= 1'b0;
      if (bite)              pulse_q <= PW'(RST_PULSE);
      else if (pulse_q != 0) pulse_q <= pulse_q - 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = {28'd0, rstflag_q, state_q, en_a, 1'b0};
      4'h4:    bus_rdata = {31'd0, en_b};
      4'h8:    bus_rdata = 32'(tb_q);
      default: bus_rdata = 32'd0;
    endcase
  end

  assign irq     = state_q;
  assign sys_rst = (pulse_q != 0);

  // R5
  a_r5_pulse_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> rstflag_q);
  // R5
  a_r5_needs_warning: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstflag_q) |-> $past(state_q));
  // R3
  a_r3_warn_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q) |-> $past(run));
  // R6
  a_r6_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'h0 && bus_wdata[2]) |=> !irq);
  // R8
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> run);
  // R9
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != 4'h0 && bus_addr != 4'h4) |=> $stable({en_a, en_b}));
endmodule

// File: tb/sim_twostage_wdog.sv
module sim_twostage_wdog;
  localparam int IV = 16;
  localparam int P  = 4;

  logic        clk = 1'b0, rst_n = 1'b0, we0 = 1'b0, we1 = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata0, rdata1, t1, t2, v;
  logic        irq0, irq1, srst0, srst1;
  int          n = 0, bad = 0;

  always #10 clk = ~clk;

  twostage_wdog #(.INTERVAL_LOG2(4), .RST_PULSE(P), .ENABLE_ONCE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we0), .bus_wdata(wdata),
    .bus_rdata(rdata0), .irq(irq0), .sys_rst(srst0));
  twostage_wdog #(.INTERVAL_LOG2(4), .RST_PULSE(P), .ENABLE_ONCE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we1), .bus_wdata(wdata),
    .bus_rdata(rdata1), .irq(irq1), .sys_rst(srst1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input bit sel, input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = sel ? rdata1 : rdata0;
    addr = '0;
  endtask

  task automatic wr(input bit sel, input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we0 = !sel; we1 = sel;
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 4'h0, v); chk("R1 csr0", v, 0);
    rd(0, 4'h4, v); chk("R1 csr1", v, 0);
    chk("R1 irq", 32'(irq0), 0);
    chk("R1 sys_rst", 32'(srst0), 0);
    rd(1, 4'h0, v); chk("R1 once csr0", v, 0);

    // R4 / R5 full timeline from enable A
    wr(0, 4'h0, 32'h2);
    for (int j = 0; j <= 40; j++) begin
      rd(0, 4'h0, v);
      chk("R2 R4 R5 csr0", v, 32'h2 | (j >= IV ? 32'h4 : 0) | (j >= 2*IV ? 32'h8 : 0));
      chk("R4 irq", 32'(irq0), 32'(j >= IV));
      chk("R5 sys_rst", 32'(srst0), 32'(j >= 2*IV && j < 2*IV + P));
      @(negedge clk);
    end

    // R6 keepalive clears both flags and restarts
    wr(0, 4'h0, 32'hE);
    for (int j = 0; j <= 17; j++) begin
      rd(0, 4'h0, v);
      chk("R6 restart", v, 32'h2 | (j >= IV ? 32'h4 : 0));
      chk("R6 no reset", 32'(srst0), 0);
      @(negedge clk);
    end
    wr(0, 4'h0, 32'h2);
    rd(0, 4'h0, v); chk("R6 zero write keeps flag", v, 32'h6);

    // R3 enable B alone keeps counting
    wr(0, 4'h4, 32'h1);
    wr(0, 4'h0, 32'h4);
    rd(0, 4'h4, v); chk("R2 csr1 enable B", v, 32'h1);
    for (int j = 0; j <= 17; j++) begin
      rd(0, 4'h0, v);
      chk("R3 single enable", v, (j >= IV ? 32'h4 : 0));
      @(negedge clk);
    end

    // R3 stop with both clear
    wr(0, 4'h4, 32'h0);
    wr(0, 4'h0, 32'h4);
    for (int j = 0; j <= 40; j++) begin
      rd(0, 4'h0, v);
      chk("R3 stopped", v, 0);
      chk("R3 stopped irq", 32'(irq0), 0);
      @(negedge clk);
    end

    // R9 unmapped
    rd(0, 4'hC, v); chk("R9 read 0xC", v, 0);
    rd(0, 4'h1, v); chk("R9 read 0x1", v, 0);
    wr(0, 4'hC, 32'hFFFF_FFFF);
    wr(0, 4'h2, 32'hFFFF_FFFF);
    rd(0, 4'h0, v); chk("R9 csr0 untouched", v, 0);
    rd(0, 4'h4, v); chk("R9 csr1 untouched", v, 0);

    // R7 timebase
    for (int k = 0; k < 5; k++) begin
      rd(0, 4'h8, t1);
      @(negedge clk);
      rd(0, 4'h8, t2);
      chk("R7 timebase step", t2, t1 + 32'd1);
    end

    // R8 enable-once lock
    wr(1, 4'h4, 32'h1);
    wr(1, 4'h4, 32'h0);
    wr(1, 4'h0, 32'h0);
    rd(1, 4'h4, v); chk("R8 enable B locked", v, 32'h1);
    rd(1, 4'h0, v); chk("R8 csr0", v, 0);
    for (int j = 2; j <= 17; j++) begin
      chk("R8 still counting", 32'(irq1), 32'(j >= IV));
      chk("R8 no reset", 32'(srst1), 0);
      @(negedge clk);
    end

    finish_run();
  end
endmodule